// File: doc/BRIEF.md
# Dual-Line Edge Interrupt Bank

This block gathers up to 24 synchronous interrupt sources and reports them to two hosts. Each host has its own interrupt line, its own status register and its own mask register. A single edge-select register is shared by both lines. It picks, for each source, whether a rising edge, a falling edge, both edges or no edge is recorded. When a selected edge occurs on a source, the status bit for that source is set in both lines' status registers. Each line's active-low output is asserted while any status bit on that line is set and unmasked.

Software reaches the block through a byte-wide synchronous port. Reads are combinational on `addr`. A read counts as a read access in a cycle where `rd_en` is high at the clock edge. A control byte chooses how status is acknowledged. In clear-on-read mode, a read access clears the status bits it returned. Otherwise, writing 1 to a status bit clears it. A second control bit decides what happens to an event that arrives while its status bit is already set. The event can be held and shown again right after the clear, or it can be dropped.

Top module: `edge_irq_bank`

## Requirements
- R1: Each line `l` (0 or 1) has its own status and mask bytes. `irqN_n` is low exactly while that line has a status bit set whose mask bit is 0.
- R2: With the default of 24 sources, the byte map is as follows. Control is at 0x00. Line 0 status is at 0x01..0x03 and line 1 status at 0x04..0x06. Line 0 mask is at 0x07..0x09 and line 1 mask at 0x0A..0x0C. Edge select is at 0x0D..0x12. Within multi-byte registers the least significant byte is at the lowest address. Unmapped addresses read 0.
- R3: Source i uses edge-select byte i>>2, at bits (i&3)*2 and (i&3)*2+1. The upper bit of the pair enables rising-edge capture and the lower bit enables falling-edge capture. Both bits may be set together.
- R4: A source whose two edge-select bits are both 0 never sets a status bit on either line.
- R5: A selected edge sets the source's status bit in both lines at once.
- R6: A mask bit of 1 keeps that source off that line's output. It does not stop the status bit from being recorded.
- R7: With control bit 0 clear, writing a status byte clears on that line only the bits written as 1. Bits written as 0 are unchanged.
- R8: With control bit 0 set, a read access to a status byte clears the bits it returned. Writes to status bytes have no effect in this mode.
- R9: With control bit 1 clear, an edge that arrives while its status bit is set is held. The bit reads 1 again after the next clear. With control bit 1 set, such an edge is dropped.
- R10: After reset, all status bits are 0, all mask bits are 1, edge select is 0, control is 0, and both outputs are high.
- R11: A source change presented before clock edge k shows in status after clock edge k+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Raw synchronous interrupt sources |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read access strobe (clears status in clear-on-read mode) |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq0_n | output | 1 | Line 0 interrupt, active low |
| irq1_n | output | 1 | Line 1 interrupt, active low |

## Verification
Several internal faults show at the ports only indirectly. A lost pending bit shows up one cycle after a clear, when the status byte reads 0 where 1 was due. A pair of edge-select bits swapped or placed at the wrong offset shows as a status bit that fails to set on the chosen edge, or that sets on the other edge, two clocks after the source moves. A shared edge-select copy that only one line sees shows as a status byte on the other line that stays 0. A mask that also gates capture shows as a status bit missing after the source is unmasked.

// File: rtl/edge_irq_bank.sv
module edge_irq_bank #(
  parameter int N_SRC  = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq0_n,
  output logic              irq1_n
);
  localparam int NB    = (N_SRC + 7) / 8;
  localparam int EB    = (N_SRC + 3) / 4;
  localparam int W     = NB * 8;
  localparam int ST_A  = 1;
  localparam int MK_A  = 1 + 2 * NB;
  localparam int ES_A  = 1 + 4 * NB;

  logic [N_SRC-1:0] src_q, src_q2;
  logic             primed;
  logic             cor, pend_dis;
  logic [EB*8-1:0]  esel;
  logic [W-1:0]     st   [2];
  logic [W-1:0]     pend [2];
  logic [W-1:0]     mk   [2];
  logic [W-1:0]     clr  [2];
  logic [W-1:0]     ev, valid;

  for (genvar i = 0; i < W; i++) begin : g_ev
    if (i < N_SRC) begin : g_live
      assign valid[i] = 1'b1;
      assign ev[i] = (esel[2*i+1] & src_q[i] & ~src_q2[i]) |
                     (esel[2*i]   & ~src_q[i] & src_q2[i]);
    end else begin : g_pad
      assign valid[i] = 1'b0;
      assign ev[i]    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      src_q2 <= '0;
      primed <= 1'b0;
    end else if (!primed) begin
      src_q  <= src_i;
      src_q2 <= src_i;
      primed <= 1'b1;
    end else begin
      src_q  <= src_i;
      src_q2 <= src_q;
    end
  end

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      clr[l] = '0;
      for (int b = 0; b < NB; b++) begin
        if (addr == ADDR_W'(ST_A + l*NB + b)) begin
          if (cor && rd_en)
            clr[l][b*8 +: 8] = st[l][b*8 +: 8];
          else if (!cor && wr_en)
            clr[l][b*8 +: 8] = wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 2; l++) begin
        st[l]   <= '0;
        pend[l] <= '0;
      end
    end else begin
      for (int l = 0; l < 2; l++) begin
        st[l]   <= ((st[l] & ~clr[l]) | ev | (clr[l] & pend[l])) & valid;
        pend[l] <= (pend[l] | (st[l] & ev & {W{~pend_dis}})) & ~(st[l] & clr[l]) & valid;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cor      <= 1'b0;
      pend_dis <= 1'b0;
      esel     <= '0;
      mk[0]    <= '1;
      mk[1]    <= '1;
    end else if (wr_en) begin
      if (addr == '0) begin
        cor      <= wdata[0];
        pend_dis <= wdata[1];
      end
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < NB; b++)
          if (addr == ADDR_W'(MK_A + l*NB + b))
            mk[l][b*8 +: 8] <= wdata;
      for (int b = 0; b < EB; b++)
        if (addr == ADDR_W'(ES_A + b))
          esel[b*8 +: 8] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = {6'b0, pend_dis, cor};
    for (int l = 0; l < 2; l++)
      for (int b = 0; b < NB; b++) begin
        if (addr == ADDR_W'(ST_A + l*NB + b)) rdata = st[l][b*8 +: 8];
        if (addr == ADDR_W'(MK_A + l*NB + b)) rdata = mk[l][b*8 +: 8];
      end
    for (int b = 0; b < EB; b++)
      if (addr == ADDR_W'(ES_A + b)) rdata = esel[b*8 +: 8];
  end

  assign irq0_n = ~|(st[0] & ~mk[0]);
  assign irq1_n = ~|(st[1] & ~mk[1]);
endmodule

// File: rtl/edge_irq_bank_chk.sv
module edge_irq_bank_chk #(
  parameter int N_SRC = 24,
  parameter int W     = 24,
  parameter int EW    = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic [EW-1:0] esel,
  input logic [W-1:0]  st0,
  input logic [W-1:0]  st1,
  input logic [W-1:0]  pd0,
  input logic [W-1:0]  pd1,
  input logic [W-1:0]  mk0,
  input logic [W-1:0]  mk1,
  input logic          pend_dis,
  input logic          irq0_n,
  input logic          irq1_n
);
  a_r6_all_masked0: assert property (@(posedge clk) disable iff (!rst_n) (&mk0) |-> irq0_n);
  a_r6_all_masked1: assert property (@(posedge clk) disable iff (!rst_n) (&mk1) |-> irq1_n);
  a_r1_quiet0: assert property (@(posedge clk) disable iff (!rst_n) (st0 == '0) |-> irq0_n);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    a_r4_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st0[i]) |-> $past(|esel[2*i +: 2]));
    a_r5_both_lines: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(st0[i]) && !$past(st1[i])) |-> st1[i]);
    a_r9_no_hold0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd0[i]) |-> $past(!pend_dis));
    a_r9_no_hold1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd1[i]) |-> $past(!pend_dis));
  end
endmodule

bind edge_irq_bank edge_irq_bank_chk #(.N_SRC(N_SRC), .W(W), .EW(EB*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .esel(esel),
  .st0(st[0]), .st1(st[1]), .pd0(pend[0]), .pd1(pend[1]),
  .mk0(mk[0]), .mk1(mk[1]), .pend_dis(pend_dis),
  .irq0_n(irq0_n), .irq1_n(irq1_n)
);

// File: tb/sim_edge_irq_bank.sv
module sim_edge_irq_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] src = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq0_n, irq1_n;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  edge_irq_bank u0 (.clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
                    .addr(addr), .wdata(wdata), .rdata(rdata), .irq0_n(irq0_n), .irq1_n(irq1_n));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic peek(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic drive(int i, logic v);
    @(negedge clk); src[i] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 32; a++) begin
      peek(5'(a), d);
      chk("R10/R2 reset map", d, (a >= 7 && a <= 12) ? 8'hFF : 8'h00);
    end
    chk("R10 irq lines", {6'b0, irq1_n, irq0_n}, 8'h03);
  endtask

  task automatic t_no_edge();
    logic [7:0] d;
    drive(0, 1); drive(0, 0);
    peek(5'h01, d); chk("R4 no edge line0", d, 8'h00);
    peek(5'h04, d); chk("R4 no edge line1", d, 8'h00);
  endtask

  task automatic t_rise_latency();
    logic [7:0] d;
    wr(5'h0D, 8'h02);
    @(negedge clk); src[0] = 1;
    @(negedge clk); addr = 5'h01; #1 chk("R11 not after first edge", rdata, 8'h00);
    @(negedge clk); #1 chk("R11 set after second edge", rdata, 8'h01);
    peek(5'h04, d); chk("R5 line1 also set", d, 8'h01);
    wr(5'h01, 8'h01); wr(5'h04, 8'h01);
    drive(0, 0);
    peek(5'h01, d); chk("R3 rise-only ignores fall", d, 8'h00);
  endtask

  task automatic t_fall_and_both();
    logic [7:0] d;
    wr(5'h0E, 8'h04);
    drive(5, 1);
    peek(5'h01, d); chk("R3 fall-only ignores rise", d, 8'h00);
    drive(5, 0);
    peek(5'h01, d); chk("R3 src5 falling sets bit5", d, 8'h20);
    wr(5'h01, 8'h20); wr(5'h04, 8'h20);
    wr(5'h12, 8'hC0);
    drive(23, 1);
    peek(5'h03, d); chk("R3 src23 rise (MSB byte)", d, 8'h80);
    wr(5'h03, 8'h80);
    peek(5'h03, d); chk("R7 w1c clears", d, 8'h00);
    drive(23, 0);
    peek(5'h03, d); chk("R3 src23 fall", d, 8'h80);
    peek(5'h06, d); chk("R5 line1 src23", d, 8'h80);
    wr(5'h03, 8'h80); wr(5'h06, 8'h80);
  endtask

  task automatic t_mask_w1c();
    logic [7:0] d;
    drive(0, 1);
    chk("R6 masked lines high", {6'b0, irq1_n, irq0_n}, 8'h03);
    wr(5'h07, 8'hFE);
    #1 chk("R1 line0 low line1 high", {6'b0, irq1_n, irq0_n}, 8'h02);
    wr(5'h01, 8'h00);
    peek(5'h01, d); chk("R7 writing 0 keeps bit", d, 8'h01);
    wr(5'h01, 8'h01);
    peek(5'h01, d); chk("R7 line0 cleared", d, 8'h00);
    peek(5'h04, d); chk("R7 line1 untouched", d, 8'h01);
    #1 chk("R1 line0 released", {7'b0, irq0_n}, 8'h01);
    wr(5'h04, 8'h01);
    wr(5'h07, 8'hFF);
    drive(0, 0);
  endtask

  task automatic t_cor();
    logic [7:0] d;
    wr(5'h00, 8'h01);
    drive(0, 1);
    wr(5'h04, 8'h01);
    peek(5'h04, d); chk("R8 write ignored", d, 8'h01);
    rd(5'h04, d); chk("R8 read returns", d, 8'h01);
    peek(5'h04, d); chk("R8 read cleared", d, 8'h00);
    peek(5'h01, d); chk("R8 other line kept", d, 8'h01);
    rd(5'h01, d);
    drive(0, 0);
    wr(5'h00, 8'h00);
  endtask

  task automatic t_pending(logic dis);
    logic [7:0] d;
    wr(5'h00, {6'b0, dis, 1'b0});
    drive(0, 1); drive(0, 0); drive(0, 1);
    wr(5'h01, 8'h01);
    peek(5'h01, d); chk(dis ? "R9 dropped with disable" : "R9 held event re-sets", d, dis ? 8'h00 : 8'h01);
    wr(5'h01, 8'h01);
    peek(5'h01, d); chk("R9 second clear empties", d, 8'h00);
    wr(5'h04, 8'h01); wr(5'h04, 8'h01);
    drive(0, 0);
    wr(5'h00, 8'h00);
  endtask

  initial begin
    #100000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_no_edge();
    t_rise_latency();
    t_fall_and_both();
    t_mask_w1c();
    t_cor();
    t_pending(1'b0);
    t_pending(1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule